// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns a 32-bit virtual address into a physical address. The virtual address is split into a 10-bit outer index, a 10-bit inner index and a 12-bit byte offset within a 4 KiB page. A small fully associative translation buffer of eight entries is searched first, in parallel, on the 20-bit page number. A hit produces the physical address without touching memory.

On a miss the unit walks a two-level table held in memory through a single read port. It reads the outer-table entry, which holds the base of the inner table, then reads the inner-table entry, which holds the frame number. Every table entry carries a valid flag. A cleared flag at either level ends the walk with a page fault instead of an address. A successful walk writes the new page-to-frame pair into the buffer, with the victim chosen by a round-robin pointer. A flush input empties the buffer. Requests use a valid/ready handshake, and the answer comes back as a one-cycle response pulse.

Top module: `pgxl_top`

## Requirements
- R1: A successful response carries `rsp_paddr` = {frame number from bits 31:12 of the inner entry, virtual address bits 11:0 unchanged}. The low 12 bits of a table entry never reach the physical address.
- R2: The first walk read is at `tbl_base + 4*va[31:22]`. The second is at `{outer_entry[31:12], 12'h000} + 4*va[21:12]`. Table entries are 32 bits wide.
- R3: On a buffer miss with valid entries, exactly two memory reads are made. `rsp_valid` rises in the cycle after the clock edge that samples the second `mem_rd_ack`.
- R4: On a buffer hit, no memory read is made and `rsp_valid` is high in the cycle right after the accepting edge.
- R5: An outer entry with bit 0 = 0 ends the walk after one read with `rsp_fault`=1. Nothing is installed, so a repeat of the same page walks again.
- R6: An inner entry with bit 0 = 0 ends the walk after two reads with `rsp_fault`=1. Nothing is installed.
- R7: Each successful walk installs its mapping in the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo 8, per install. The ninth distinct page evicts the first.
- R8: While `flush` is high, `req_ready` is low. A flush cycle invalidates every buffer entry, and an install in the same cycle is dropped. Afterwards every page misses.
- R9: `req_ready` is high only while the unit is idle. Once `mem_rd_req` is raised, it and `mem_rd_addr` hold steady until `mem_rd_ack` is sampled.
- R10: `rsp_valid` is a single-cycle pulse. On a fault, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| tbl_base | input | 32 | Byte address of the outer table, sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address (zero on a fault) |
| rsp_fault | output | 1 | Page fault flag for this response |
| mem_rd_req | output | 1 | Table read request, held until acknowledged |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Table entry read from memory |

## Verification
The hardest state to reach is the buffer wrapping around: the pointer only moves on a successful walk, so an eviction needs eight distinct successful walks first. Faulting walks interleaved among them must leave the pointer alone. The stimulus flushes the buffer and fills it with eight pages spread over different outer indices. It confirms all eight now hit, then adds a ninth page. A reference model keeps its own eight-slot list and pointer, so it predicts which earlier page now misses and how many reads each request costs. Memory latency is varied between requests, so response timing is checked against the actual acknowledge cycle rather than a fixed count.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OUTER = 2'd1,
    WS_INNER = 2'd2,
    WS_RESP  = 2'd3
  } walk_st_e;

  // Position of the present flag inside a table entry
  localparam int unsigned ENT_VLD_BIT = 0;

endpackage

// File: rtl/pgxl_tlb.sv
module pgxl_tlb #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20,
  parameter int unsigned NUM_E = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn
);

  localparam int unsigned IDX_W = (NUM_E > 1) ? $clog2(NUM_E) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_E - 1);

  logic [NUM_E-1:0] vld_q, vld_d;
  logic [VPN_W-1:0] tag_q [NUM_E];
  logic [PFN_W-1:0] frm_q [NUM_E];
  logic [NUM_E-1:0] match;
  logic [NUM_E-1:0] slot_we;
  logic [IDX_W-1:0] rr_q, rr_d;
  logic             do_fill;

  // flush has priority over an install in the same cycle
  assign do_fill = wr_en && !flush;

  // parallel compare and per-slot write enables
  for (genvar g = 0; g < NUM_E; g++) begin : g_slot
    assign match[g]   = vld_q[g] && (tag_q[g] == lk_vpn);
    assign slot_we[g] = do_fill && (rr_q == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (slot_we[g]) begin
        tag_q[g] <= wr_vpn;
        frm_q[g] <= wr_pfn;
      end
    end
  end

  assign lk_hit = |match;

  always_comb begin
    lk_pfn = '0;
    for (int k = 0; k < NUM_E; k++) begin
      if (match[k]) lk_pfn = lk_pfn | frm_q[k];
    end
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      vld_d = '0;
    end else if (do_fill) begin
      vld_d = vld_q | slot_we;
      rr_d  = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

endmodule

// File: rtl/pgxl_walker.sv
module pgxl_walker
  import pgxl_pkg::*;
#(
  parameter int unsigned OUT_W = 10,
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [PTE_W-1:0]                 tbl_base,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [OUT_W+IN_W+OFF_W-1:0]      req_vaddr,
  output logic [OUT_W+IN_W-1:0]            lk_vpn,
  input  logic                             lk_hit,
  input  logic [PTE_W-OFF_W-1:0]           lk_pfn,
  output logic                             mem_rd_req,
  output logic [PTE_W-1:0]                 mem_rd_addr,
  input  logic                             mem_rd_ack,
  input  logic [PTE_W-1:0]                 mem_rd_data,
  output logic                             rsp_valid,
  output logic [PTE_W-1:0]                 rsp_paddr,
  output logic                             rsp_fault,
  output logic                             fill_en,
  output logic [OUT_W+IN_W-1:0]            fill_vpn,
  output logic [PTE_W-OFF_W-1:0]           fill_pfn
);

  localparam int unsigned VA_W  = OUT_W + IN_W + OFF_W;
  localparam int unsigned VPN_W = OUT_W + IN_W;
  localparam int unsigned PFN_W = PTE_W - OFF_W;
  localparam int unsigned PA_W  = PTE_W;

  walk_st_e          st_q, st_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic [PA_W-1:0]   base_q, base_d;
  logic [PFN_W-1:0]  itab_q, itab_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic              flt_q, flt_d;

  logic [OUT_W-1:0]  oidx;
  logic [IN_W-1:0]   iidx;
  logic [OFF_W-1:0]  offs;
  logic [PA_W-1:0]   outer_addr;
  logic [PA_W-1:0]   inner_addr;
  logic              ent_ok;
  logic [PFN_W-1:0]  ent_frame;

  assign oidx       = va_q[VA_W-1 -: OUT_W];
  assign iidx       = va_q[OFF_W +: IN_W];
  assign offs       = va_q[OFF_W-1:0];
  assign outer_addr = base_q + (PA_W'(oidx) << 2);
  assign inner_addr = {itab_q, {OFF_W{1'b0}}} + (PA_W'(iidx) << 2);
  assign ent_ok     = mem_rd_data[ENT_VLD_BIT];
  assign ent_frame  = mem_rd_data[PTE_W-1:OFF_W];

  assign lk_vpn     = req_vaddr[VA_W-1:OFF_W];
  assign req_ready  = (st_q == WS_IDLE) && !flush;
  assign mem_rd_req = (st_q == WS_OUTER) || (st_q == WS_INNER);
  assign mem_rd_addr = (st_q == WS_OUTER) ? outer_addr : inner_addr;
  assign rsp_valid  = (st_q == WS_RESP);
  assign rsp_paddr  = pa_q;
  assign rsp_fault  = flt_q;
  assign fill_vpn   = va_q[VA_W-1:OFF_W];
  assign fill_pfn   = ent_frame;

  always_comb begin
    st_d    = st_q;
    va_d    = va_q;
    base_d  = base_q;
    itab_d  = itab_q;
    pa_d    = pa_q;
    flt_d   = flt_q;
    fill_en = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (req_valid && req_ready) begin
          va_d   = req_vaddr;
          base_d = tbl_base;
          if (lk_hit) begin
            pa_d  = {lk_pfn, req_vaddr[OFF_W-1:0]};
            flt_d = 1'b0;
            st_d  = WS_RESP;
          end else begin
            st_d  = WS_OUTER;
          end
        end
      end
      WS_OUTER: begin
        if (mem_rd_ack) begin
          if (!ent_ok) begin
            pa_d  = '0;
            flt_d = 1'b1;
            st_d  = WS_RESP;
          end else begin
            itab_d = ent_frame;
            st_d   = WS_INNER;
          end
        end
      end
      WS_INNER: begin
        if (mem_rd_ack) begin
          if (!ent_ok) begin
            pa_d  = '0;
            flt_d = 1'b1;
          end else begin
            pa_d    = {ent_frame, offs};
            flt_d   = 1'b0;
            fill_en = 1'b1;
          end
          st_d = WS_RESP;
        end
      end
      default: begin
        st_d = WS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      va_q   <= '0;
      base_q <= '0;
      itab_q <= '0;
      pa_q   <= '0;
      flt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      va_q   <= va_d;
      base_q <= base_d;
      itab_q <= itab_d;
      pa_q   <= pa_d;
      flt_q  <= flt_d;
    end
  end

endmodule

// File: rtl/pgxl_top.sv
module pgxl_top #(
  parameter int unsigned OUT_W = 10,
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned NUM_E = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [PTE_W-1:0]              tbl_base,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [OUT_W+IN_W+OFF_W-1:0]   req_vaddr,
  output logic                          rsp_valid,
  output logic [PTE_W-1:0]              rsp_paddr,
  output logic                          rsp_fault,
  output logic                          mem_rd_req,
  output logic [PTE_W-1:0]              mem_rd_addr,
  input  logic                          mem_rd_ack,
  input  logic [PTE_W-1:0]              mem_rd_data
);

  localparam int unsigned VPN_W = OUT_W + IN_W;
  localparam int unsigned PFN_W = PTE_W - OFF_W;

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic             fill_en;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;

  pgxl_tlb #(
    .VPN_W(VPN_W),
    .PFN_W(PFN_W),
    .NUM_E(NUM_E)
  ) tlb_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .lk_vpn (lk_vpn),
    .lk_hit (lk_hit),
    .lk_pfn (lk_pfn),
    .wr_en  (fill_en),
    .wr_vpn (fill_vpn),
    .wr_pfn (fill_pfn)
  );

  pgxl_walker #(
    .OUT_W(OUT_W),
    .IN_W (IN_W),
    .OFF_W(OFF_W),
    .PTE_W(PTE_W)
  ) walk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .tbl_base    (tbl_base),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .lk_vpn      (lk_vpn),
    .lk_hit      (lk_hit),
    .lk_pfn      (lk_pfn),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .rsp_valid   (rsp_valid),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (rsp_fault),
    .fill_en     (fill_en),
    .fill_vpn    (fill_vpn),
    .fill_pfn    (fill_pfn)
  );

endmodule

// File: rtl/pgxl_chk.sv
module pgxl_chk #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            mem_rd_req,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_rd_ack
);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
  end

  // R1: offset bits of an accepted request come back untouched
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_q));

  // R4: an accepted request answers at once or starts a walk
  a_r4_accept_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_rd_req));

  // R8: no acceptance while flushing
  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  // R9: busy while reading memory
  a_r9_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);

  // R9: read request holds steady until acknowledged
  a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R10: response is a single-cycle pulse
  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: fault carries a zero address
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

endmodule

bind pgxl_top pgxl_chk #(
  .OFF_W(OFF_W),
  .VA_W (OUT_W + IN_W + OFF_W),
  .PA_W (PTE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .rsp_valid   (rsp_valid),
  .rsp_paddr   (rsp_paddr),
  .rsp_fault   (rsp_fault),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_ack  (mem_rd_ack)
);

// File: tb/pgxl_tb_top.sv
`timescale 1ns/1ps
module pgxl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic [31:0] tbl_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack;
  logic [31:0] mem_rd_data;

  pgxl_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- memory image and responder
  logic [31:0] pt [logic [31:0]];
  int          lat = 0;
  int          wcnt = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_a [2];
  int          ack_cyc = 0;

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    if (pt.exists(a)) return pt[a];
    return 32'h0;
  endfunction

  initial begin
    mem_rd_ack  = 1'b0;
    mem_rd_data = 32'h0;
    forever begin
      @(negedge clk);
      if (mem_rd_ack) begin
        mem_rd_ack = 1'b0;
      end else if (mem_rd_req) begin
        if (wcnt >= lat) begin
          mem_rd_ack  = 1'b1;
          mem_rd_data = rdmem(mem_rd_addr);
          if (rd_cnt < 2) rd_a[rd_cnt] = mem_rd_addr;
          rd_cnt++;
          ack_cyc = cyc;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  // ---------------- reference model of the buffer
  logic [19:0] m_vpn [8];
  logic [19:0] m_pfn [8];
  bit          m_v   [8];
  int          m_ptr = 0;

  localparam logic [31:0] BASE = 32'h0004_0100;

  function automatic logic [31:0] itab_of(input logic [9:0] o);
    return 32'h0020_0000 + (32'(o) << 12);
  endfunction

  task automatic map_page(input logic [31:0] va, input logic [19:0] pfn,
                          input bit ov, input bit iv);
    logic [31:0] it;
    it = itab_of(va[31:22]);
    pt[BASE + (32'(va[31:22]) << 2)] = {it[31:12], 11'h3A2, ov};
    pt[it + (32'(va[21:12]) << 2)]   = {pfn, 11'h155, iv};
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R8 ready low during flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    for (int k = 0; k < 8; k++) m_v[k] = 0;
  endtask

  // one translation, compared against the model
  task automatic xlate(input logic [31:0] va, input string tag);
    bit          hit;
    int          slot;
    int          exp_reads;
    bit          exp_flt;
    logic [31:0] exp_pa;
    logic [31:0] a0, a1, e0, e1;
    bit          busy_ok;
    int          n;
    hit = 0; slot = 0;
    for (int k = 0; k < 8; k++)
      if (m_v[k] && m_vpn[k] == va[31:12]) begin hit = 1; slot = k; end
    a0 = BASE + (32'(va[31:22]) << 2);
    e0 = rdmem(a0);
    a1 = {e0[31:12], 12'h000} + (32'(va[21:12]) << 2);
    e1 = rdmem(a1);
    if (hit) begin
      exp_reads = 0; exp_flt = 0; exp_pa = {m_pfn[slot], va[11:0]};
    end else if (!e0[0]) begin
      exp_reads = 1; exp_flt = 1; exp_pa = 32'h0;
    end else if (!e1[0]) begin
      exp_reads = 2; exp_flt = 1; exp_pa = 32'h0;
    end else begin
      exp_reads = 2; exp_flt = 0; exp_pa = {e1[31:12], va[11:0]};
      m_vpn[m_ptr] = va[31:12];
      m_pfn[m_ptr] = e1[31:12];
      m_v[m_ptr]   = 1;
      m_ptr = (m_ptr + 1) % 8;
    end

    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      chk(rsp_valid == 1'b1, {"R4 hit responds next cycle ", tag}, 32'(rsp_valid), 32'd1);
    end else begin
      busy_ok = 1; n = 0;
      while (!rsp_valid && n < 500) begin
        if (req_ready) busy_ok = 0;
        @(negedge clk);
        n++;
      end
      chk(busy_ok, {"R9 not ready while walking ", tag}, 32'(busy_ok), 32'd1);
      chk(rsp_valid && cyc == ack_cyc + 1, {"R3 response cycle after last ack ", tag},
          32'(cyc), 32'(ack_cyc + 1));
    end
    chk(rd_cnt == exp_reads, {"R3/R4/R5/R6 read count ", tag}, 32'(rd_cnt), 32'(exp_reads));
    chk(rsp_fault == exp_flt, {"R5/R6 fault flag ", tag}, 32'(rsp_fault), 32'(exp_flt));
    chk(rsp_paddr == exp_pa, {"R1/R10 physical address ", tag}, rsp_paddr, exp_pa);
    if (exp_reads >= 1 && rd_cnt >= 1)
      chk(rd_a[0] == a0, {"R2 outer read address ", tag}, rd_a[0], a0);
    if (exp_reads == 2 && rd_cnt >= 2)
      chk(rd_a[1] == a1, {"R2 inner read address ", tag}, rd_a[1], a1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, {"R10 single-cycle response ", tag}, 32'(rsp_valid), 32'd0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus
  logic [31:0] pg [10];

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = 32'h0;
    tbl_base = BASE;
    for (int k = 0; k < 8; k++) m_v[k] = 0;
    for (int k = 0; k < 10; k++) begin
      pg[k] = {10'(k * 37 + 3), 10'(k * 91 + 5), 12'h000};
      map_page(pg[k], 20'hA0000 + 20'(k * 4099), 1'b1, 1'b1);
    end
    map_page(32'hFFC0_0000, 20'h12345, 1'b0, 1'b1);   // outer invalid
    map_page(32'hFF80_1000, 20'h54321, 1'b1, 1'b0);   // inner invalid
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R10 quiet after reset",
        32'({rsp_valid, mem_rd_req}), 32'd0);

    // R1 R2 R3 R4: miss then hits with other offsets
    lat = 0; xlate(pg[0] | 32'h0ABC, "p0 miss");
    xlate(pg[0] | 32'h0FFF, "p0 hit");
    lat = 2; xlate(pg[1] | 32'h0001, "p1 miss lat2");
    xlate(pg[1], "p1 hit");

    // R5 outer fault, not installed
    lat = 1; xlate(32'hFFC0_0123, "outer fault");
    xlate(32'hFFC0_0456, "outer fault again");
    // R6 inner fault, not installed
    xlate(32'hFF80_1789, "inner fault");
    lat = 3; xlate(32'hFF80_1000, "inner fault again");

    // R7 round robin fill and eviction
    do_flush();
    lat = 0;
    for (int k = 0; k < 8; k++) xlate(pg[k] | 32'(k), "r7 fill");
    for (int k = 0; k < 8; k++) xlate(pg[k] | 32'h800, "r7 all hit");
    xlate(pg[8] | 32'h010, "r7 ninth page");
    xlate(pg[0] | 32'h020, "r7 first page evicted");
    xlate(pg[2] | 32'h030, "r7 third page kept");
    xlate(pg[1] | 32'h040, "r7 second page evicted");

    // R8 flush forgets everything
    do_flush();
    lat = 1;
    xlate(pg[2] | 32'h333, "R8 after flush");
    xlate(pg[2] | 32'h444, "R8 refilled");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule